// File: doc/BRIEF.md
# Two-Wire Bus Input Conditioner and Event Detector

This block sits at the pin edge of a two-wire serial slave. It brings the raw clock line and data line into the system clock domain through a synchroniser and a spike filter. It then reports bus activity as single-cycle strobes that the byte engine downstream can act on directly.

The spike filter is a per-line persistence counter. The clean level of a line moves only after the synchronised input has disagreed with it for `FILT_CYCLES` system clocks in a row. With the default of 6 cycles at 50 MHz, any excursion of 100 ns or less is discarded before any framing decision is made.

On the clean levels, the detector recognises the two framing conditions:
- a data-line fall while the clock line stays high opens a transfer;
- a data-line rise while the clock line stays high closes it.

Data-line moves while the clock line is low are ordinary data and raise nothing. Separate strobes mark every clock rise, which is where incoming bits are sampled, and every clock fall, after which outgoing bits may change. A busy flag spans from opening to closing. An opening seen while busy is additionally flagged as a repeated opening. The design assumes a system clock at least about 20 times the bus clock.

Top module: `twl_bus_conditioner`

## Requirements
- R1: After reset, `scl_clean` and `sda_clean` are 1, `bus_busy` is 0 and every strobe output is 0.
- R2: A change on either raw line that lasts `FILT_CYCLES`-1 or fewer system clocks never alters the matching clean level and raises no strobe.
- R3: A change held for `FILT_CYCLES` or more system clocks is accepted. The clean level follows exactly `SYNC_STAGES`+`FILT_CYCLES` rising clock edges after the raw change (8 with defaults).
- R4: A fall of `sda_clean` from 1 to 0 while `scl_clean` is 1 before and after produces exactly one `start_evt` pulse.
- R5: A rise of `sda_clean` from 0 to 1 while `scl_clean` is 1 before and after produces exactly one `stop_evt` pulse.
- R6: Changes of the data line while the clock line is low produce neither `start_evt` nor `stop_evt`.
- R7: Each rise of `scl_clean` produces exactly one `scl_rise` pulse, and each fall produces exactly one `scl_fall` pulse.
- R8: `bus_busy` becomes 1 in the cycle `start_evt` is high and becomes 0 in the cycle `stop_evt` is high.
- R9: A start condition while `bus_busy` is 1 raises `rstart_evt` together with `start_evt`, and `bus_busy` stays 1. A start from idle leaves `rstart_evt` at 0.
- R10: Every strobe output is high for exactly one system clock per detected event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw | input | 1 | Unsynchronised clock line from the pad |
| sda_raw | input | 1 | Unsynchronised data line from the pad |
| scl_clean | output | 1 | Filtered clock line level |
| sda_clean | output | 1 | Filtered data line level |
| scl_rise | output | 1 | One-cycle strobe on a clean clock rise |
| scl_fall | output | 1 | One-cycle strobe on a clean clock fall |
| start_evt | output | 1 | One-cycle strobe on a start condition |
| rstart_evt | output | 1 | One-cycle strobe on a start condition while busy |
| stop_evt | output | 1 | One-cycle strobe on a stop condition |
| bus_busy | output | 1 | High from a start condition until a stop condition |

## Verification
The properties rely on two things about the stimulus:
- the raw lines hold each level for whole system-clock cycles;
- the two lines never change in the same cycle.

Only under these conditions is a framing condition distinguishable from a data change. The bench drives both lines only on falling clock edges and moves one line per step. Each level is held well past the filter and pipeline depth, so every strobe from one step lands inside that step's observation window. Glitches are applied only to an otherwise quiet bus, so a rejected spike cannot overlap a real transition.

// File: rtl/twl_pkg.sv
package twl_pkg;

    localparam int unsigned LINE_SCL  = 0;
    localparam int unsigned LINE_SDA  = 1;
    localparam int unsigned NUM_LINES = 2;

    // Registered state of the framing detector
    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
        logic busy;
        logic start;
        logic rstart;
        logic stop;
        logic rise;
        logic fall;
    } frame_state_t;

endpackage

// File: rtl/twl_line_filter.sv
module twl_line_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_clean
);

    localparam int unsigned CNT_W = $clog2(FILT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   level;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic        synced;

    assign synced = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], line_raw};
        if (synced == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.level = synced;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync  <= '1;
            st_q.cnt   <= '0;
            st_q.level <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_clean = st_q.level;

    // The persistence counter never runs past its terminal value
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST);

    // Without a full count the filtered level cannot move
    assert_hold_until_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != CNT_LAST) |=> $stable(st_q.level));

    // A level change always adopts the synchronised value
    assert_follow_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level != $past(st_q.level)) |-> ($past(synced) == st_q.level));

endmodule

// File: rtl/twl_frame_detect.sv
module twl_frame_detect
    import twl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic rstart_evt,
    output logic stop_evt,
    output logic bus_busy
);

    frame_state_t st_d, st_q;
    logic         scl_steady_hi;

    always_comb begin
        st_d          = st_q;
        scl_steady_hi = scl & st_q.scl_prev;
        st_d.scl_prev = scl;
        st_d.sda_prev = sda;
        st_d.start    = scl_steady_hi &  st_q.sda_prev & ~sda;
        st_d.stop     = scl_steady_hi & ~st_q.sda_prev &  sda;
        st_d.rise     = ~st_q.scl_prev &  scl;
        st_d.fall     =  st_q.scl_prev & ~scl;
        st_d.rstart   = st_d.start & st_q.busy;
        if (st_d.start) begin
            st_d.busy = 1'b1;
        end else if (st_d.stop) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.scl_prev <= 1'b1;
            st_q.sda_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_rise   = st_q.rise;
    assign scl_fall   = st_q.fall;
    assign start_evt  = st_q.start;
    assign rstart_evt = st_q.rstart;
    assign stop_evt   = st_q.stop;
    assign bus_busy   = st_q.busy;

    assert_start_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> scl);

    assert_stop_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |-> scl);

    assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise |=> !scl_rise) and (scl_fall |=> !scl_fall));

    assert_busy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> start_evt);

    assert_busy_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy) |-> stop_evt);

    assert_rstart_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_evt |-> (bus_busy && $past(bus_busy)));

    assert_start_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !start_evt);

    assert_stop_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !stop_evt);

endmodule

// File: rtl/twl_bus_conditioner.sv
module twl_bus_conditioner
    import twl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_clean,
    output logic sda_clean,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic rstart_evt,
    output logic stop_evt,
    output logic bus_busy
);

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean_lines;

    assign raw_lines[LINE_SCL] = scl_raw;
    assign raw_lines[LINE_SDA] = sda_raw;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        twl_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_CYCLES (FILT_CYCLES)
        ) i_filter (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_raw   (raw_lines[g]),
            .line_clean (clean_lines[g])
        );
    end

    assign scl_clean = clean_lines[LINE_SCL];
    assign sda_clean = clean_lines[LINE_SDA];

    twl_frame_detect i_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl        (clean_lines[LINE_SCL]),
        .sda        (clean_lines[LINE_SDA]),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_evt  (start_evt),
        .rstart_evt (rstart_evt),
        .stop_evt   (stop_evt),
        .bus_busy   (bus_busy)
    );

    // No start or stop is reported while the clock line is low (R6)
    assert_no_frame_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_clean |-> !(start_evt || stop_evt));

endmodule

// File: tb/test_twl_bus_conditioner.sv
module test_twl_bus_conditioner;

    localparam int unsigned FILT = 6;
    localparam int unsigned HOLD = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_raw = 1'b1;
    logic sda_raw = 1'b1;
    logic scl_clean, sda_clean, scl_rise, scl_fall;
    logic start_evt, rstart_evt, stop_evt, bus_busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_start, n_stop, n_rstart, n_rise, n_fall;
    int min_scl, min_sda;

    always #10 clk = ~clk;

    twl_bus_conditioner #(.SYNC_STAGES(2), .FILT_CYCLES(FILT)) i_twl_bus_conditioner (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .scl_clean(scl_clean), .sda_clean(sda_clean),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .rstart_evt(rstart_evt),
        .stop_evt(stop_evt), .bus_busy(bus_busy)
    );

    // Vector bits: scl, sda, exp busy, start, stop, rstart, rise, fall
    localparam logic [7:0] VEC [0:15] = '{
        8'b1_0_1_1_0_0_0_0,
        8'b0_0_1_0_0_0_0_1,
        8'b0_1_1_0_0_0_0_0,
        8'b1_1_1_0_0_0_1_0,
        8'b0_1_1_0_0_0_0_1,
        8'b0_0_1_0_0_0_0_0,
        8'b1_0_1_0_0_0_1_0,
        8'b1_1_0_0_1_0_0_0,
        8'b1_0_1_1_0_0_0_0,
        8'b0_0_1_0_0_0_0_1,
        8'b0_1_1_0_0_0_0_0,
        8'b1_1_1_0_0_0_1_0,
        8'b1_0_1_1_0_1_0_0,
        8'b0_0_1_0_0_0_0_1,
        8'b1_0_1_0_0_0_1_0,
        8'b1_1_0_0_1_0_0_0
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_start = 0; n_stop = 0; n_rstart = 0; n_rise = 0; n_fall = 0;
        min_scl = 1; min_sda = 1;
    endtask

    task automatic tick();
        @(negedge clk);
        n_start  += int'(start_evt);
        n_stop   += int'(stop_evt);
        n_rstart += int'(rstart_evt);
        n_rise   += int'(scl_rise);
        n_fall   += int'(scl_fall);
        if (!scl_clean) min_scl = 0;
        if (!sda_clean) min_sda = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        clear_counts();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 scl_clean", int'(scl_clean), 1);
        check("R1 sda_clean", int'(sda_clean), 1);
        check("R1 bus_busy", int'(bus_busy), 0);
        check("R1 strobes", int'({start_evt, rstart_evt, stop_evt, scl_rise, scl_fall}), 0);
        rst_n = 1'b1;
        ticks(4);

        // R3: latency of an accepted change
        clear_counts();
        scl_raw = 1'b0;
        lat = 0;
        for (int i = 1; i <= 20; i++) begin
            tick();
            if (lat == 0 && scl_clean == 1'b0) lat = i;
        end
        check("R3 latency", lat, 8);
        scl_raw = 1'b1;
        ticks(HOLD);
        check("R7 fall count", n_fall, 1);
        check("R7 rise count", n_rise, 1);
        check("R6 no start on scl only", n_start, 0);

        // R2: data spike while clock high is rejected
        clear_counts();
        sda_raw = 1'b0;
        ticks(FILT - 1);
        sda_raw = 1'b1;
        ticks(HOLD);
        check("R2 sda level held", min_sda, 1);
        check("R2 no start", n_start, 0);
        check("R2 busy", int'(bus_busy), 0);

        // R2: clock spike rejected
        clear_counts();
        scl_raw = 1'b0;
        ticks(FILT - 1);
        scl_raw = 1'b1;
        ticks(HOLD);
        check("R2 scl level held", min_scl, 1);
        check("R2 no fall", n_fall, 0);

        // Vector table walk: R4 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < 16; v++) begin
            clear_counts();
            scl_raw = VEC[v][7];
            sda_raw = VEC[v][6];
            ticks(HOLD);
            check($sformatf("R3 scl level v%0d", v), int'(scl_clean), int'(VEC[v][7]));
            check($sformatf("R3 sda level v%0d", v), int'(sda_clean), int'(VEC[v][6]));
            check($sformatf("R8 busy v%0d", v), int'(bus_busy), int'(VEC[v][5]));
            check($sformatf("R4 R10 start v%0d", v), n_start, int'(VEC[v][4]));
            check($sformatf("R5 R10 stop v%0d", v), n_stop, int'(VEC[v][3]));
            check($sformatf("R9 rstart v%0d", v), n_rstart, int'(VEC[v][2]));
            check($sformatf("R7 rise v%0d", v), n_rise, int'(VEC[v][1]));
            check($sformatf("R7 fall v%0d", v), n_fall, int'(VEC[v][0]));
        end

        // R3: a full-width data pulse passes and frames a start then a stop
        clear_counts();
        sda_raw = 1'b0;
        ticks(FILT);
        sda_raw = 1'b1;
        ticks(HOLD);
        check("R3 pulse passed", min_sda, 0);
        check("R4 start from pulse", n_start, 1);
        check("R5 stop from pulse", n_stop, 1);
        check("R9 no rstart from idle", n_rstart, 0);
        check("R8 busy after stop", int'(bus_busy), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule